// File: doc/BRIEF.md
# Transactional Write Buffer Cache

A small fully-associative side store placed next to a core's first-level cache. It records every word that a hardware transaction touches. Each slot keeps the word address, the value the word had before the transaction first touched it, and the speculative value the transaction has produced since then. Ordinary loads and stores do not come here; the core routes only transactional accesses to this block.

A transaction opens with a begin pulse and closes with a commit pulse or an explicit abort pulse. On a commit, the block walks its slots in a fixed order and sends every changed word out through a write-drain port. It holds off new accesses while it does this, then reports completion. On any abort, every slot is dropped in a single cycle and the pre-transaction values remain the visible state. An abort has one of three causes. A coherence snoop invalidation can hit a tracked word. The core can request an abort. Or a new word can arrive when every slot is already taken; that overflow abort tells software to retry the work in a slower mode that has no capacity limit. After an abort, the block reports the cause and refuses accesses until the next begin.

Top module: `tx_write_buffer`

## Requirements
- R1: After reset there is no open transaction, `abortPending` is 0, `abortCause` is 2'b00, and `accHit`, `accStall`, `drainValid` and `commitDone` are all 0.
- R2: With no open transaction, an access is refused. `accHit` is 0 and nothing is recorded, so a word written while idle still misses in the next transaction and reads as the backing-memory value.
- R3: In an open transaction, the first access to a word with a free slot allocates that slot and captures the backing value, read combinationally through `memRdAddr`/`memRdData`, as the old copy. In that cycle `accHit` is 0 and `accRdata` equals the backing value. Any later access to the same word has `accHit` 1 and `accRdata` equal to the slot's new copy.
- R4: A transactional write sets only the new copy: on allocation the new copy takes the write data, and on a hit the new copy is replaced. The old copy is never changed by a write.
- R5: A snoop invalidation (`snoopValid`) whose address matches a recorded word during an open transaction aborts it. From the next cycle `abortPending` is 1 and `abortCause` is 2'b10 (conflict). A snoop to an unrecorded word has no effect.
- R6: A `txAbort` pulse in an open transaction aborts it with `abortCause` 2'b01 (explicit).
- R7: An access to an unrecorded word when all ENTRIES slots are occupied evicts nothing. It aborts the transaction with `abortCause` 2'b11 (overflow).
- R8: Any abort drops every slot in the same edge. Until the next `txBegin`, accesses are refused with `accHit` 0, and `txCommit`, `txAbort` and snoops are ignored.
- R9: The cycle after a `txCommit`, draining starts and lasts exactly ENTRIES cycles. Each cycle examines one slot in ascending slot order, and slots are allocated lowest free index first. `drainValid` is 1 exactly when that slot is occupied and its new copy differs from its old copy, and it then presents that slot's address and new copy. `accStall` is 1 and accesses are refused for the whole drain. `commitDone` is 1 in the last drain cycle only, after which all slots are empty and the block is idle.
- R10: Priority within one cycle is snoop conflict, then explicit abort, then commit, then access. A commit whose cycle also carries a snoop that hits a recorded word ends in a conflict abort with no drain.
- R11: `txBegin` while idle or aborted opens a transaction and clears `abortPending` and `abortCause`. While aborted, the cause holds until that `txBegin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Open-transaction pulse |
| txCommit | input | 1 | Commit request pulse |
| txAbort | input | 1 | Explicit abort request pulse |
| accValid | input | 1 | Transactional access request |
| accWrite | input | 1 | Access is a write |
| accAddr | input | ADDR_W | Word address of the access |
| accWdata | input | DATA_W | Write data |
| accRdata | output | DATA_W | Read data: new copy on hit, backing value otherwise |
| accHit | output | 1 | Accepted access matched a recorded word |
| accStall | output | 1 | Commit drain in progress; accesses refused |
| memRdAddr | output | ADDR_W | Backing-memory read address |
| memRdData | input | DATA_W | Backing-memory read data (combinational) |
| snoopValid | input | 1 | Remote invalidation snoop |
| snoopAddr | input | ADDR_W | Snooped word address |
| drainValid | output | 1 | A changed word is being written back |
| drainAddr | output | ADDR_W | Write-back address |
| drainData | output | DATA_W | Write-back data |
| commitDone | output | 1 | Last drain cycle of a commit |
| abortPending | output | 1 | Transaction has aborted, waiting for a begin |
| abortCause | output | 2 | 00 none, 01 explicit, 10 conflict, 11 overflow |

## Verification
The bench aims at the collisions in this block's priority order. One case puts a snoop and a commit in the same cycle; a design that let the commit win would drain a transaction that had already lost its data. Another fills all slots and then touches one more word; a design that evicted a slot or wrapped the free search would hit a stale word or drain it later, where it should report overflow. Writes that put a word back to its original value check that the drain filters on a real change. Accesses issued during the drain and after an abort check the refusal rules, because a design that kept serving them would change drained data or let a later transaction hit on a dead word.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_ABORTED = 2'd3
  } twbState_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_EXPLICIT = 2'b01,
    CAUSE_CONFLICT = 2'b10,
    CAUSE_OVERFLOW = 2'b11
  } twbCause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // drop every slot at this edge
    logic accept;    // the presented access is serviced this cycle
  } twbStrobe_t;

endpackage

// File: rtl/twb_datapath.sv
module twb_datapath
  import twb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  twbStrobe_t        stb,
  input  logic [IDX_W-1:0]  drainPtr,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              lookupHit,
  output logic              freeAvail,
  output logic              snoopHit,
  output logic              slotDirty,
  output logic [DATA_W-1:0] accRdata,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData
);

  logic [ENTRIES-1:0] validVec;
  logic [ADDR_W-1:0]  tagMem  [ENTRIES];
  logic [DATA_W-1:0]  oldMem  [ENTRIES];
  logic [DATA_W-1:0]  newMem  [ENTRIES];

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] snoopVec;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   allocIdx;

  // Per-slot compare
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g]   = validVec[g] && (tagMem[g] == accAddr);
    assign snoopVec[g] = validVec[g] && (tagMem[g] == snoopAddr);
  end

  assign lookupHit = |hitVec;
  assign snoopHit  = |snoopVec;
  assign freeAvail = ~&validVec;

  // Encode the matching slot and the lowest free slot
  always_comb begin
    hitIdx   = '0;
    allocIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i])    hitIdx   = IDX_W'(i);
      if (!validVec[i]) allocIdx = IDX_W'(i);
    end
  end

  assign accRdata  = lookupHit ? newMem[hitIdx] : memRdData;
  assign drainAddr = tagMem[drainPtr];
  assign drainData = newMem[drainPtr];
  assign slotDirty = validVec[drainPtr] && (newMem[drainPtr] != oldMem[drainPtr]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (stb.clearAll) begin
      validVec <= '0;
    end else if (stb.accept) begin
      if (lookupHit) begin
        if (accWrite) newMem[hitIdx] <= accWdata;
      end else begin
        validVec[allocIdx] <= 1'b1;
        tagMem[allocIdx]   <= accAddr;
        oldMem[allocIdx]   <= memRdData;
        newMem[allocIdx]   <= accWrite ? accWdata : memRdData;
      end
    end
  end

  // Every slot is gone one edge after a clear request
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (validVec == '0));

  // Allocation never happens without a free slot (no eviction)
  p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && !lookupHit) |-> freeAvail);

endmodule

// File: rtl/twb_control.sv
module twb_control
  import twb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txBegin,
  input  logic             txCommit,
  input  logic             txAbort,
  input  logic             accValid,
  input  logic             snoopValid,
  input  logic             lookupHit,
  input  logic             freeAvail,
  input  logic             snoopHit,
  input  logic             slotDirty,
  output twbStrobe_t       stb,
  output logic [IDX_W-1:0] drainPtr,
  output logic             accHit,
  output logic             accStall,
  output logic             drainValid,
  output logic             commitDone,
  output logic             abortPending,
  output logic [1:0]       abortCause
);

  twbState_e state;
  twbCause_e cause;

  logic inActive, inDrain;
  logic conflictNow, explicitNow, commitNow, accessNow, overflowNow, abortNow;
  logic drainLast;

  assign inActive = (state == ST_ACTIVE);
  assign inDrain  = (state == ST_DRAIN);

  // Fixed priority: conflict > explicit abort > commit > access
  assign conflictNow = inActive && snoopValid && snoopHit;
  assign explicitNow = inActive && txAbort && !conflictNow;
  assign commitNow   = inActive && txCommit && !conflictNow && !txAbort;
  assign accessNow   = inActive && accValid && !conflictNow && !txAbort && !txCommit;
  assign overflowNow = accessNow && !lookupHit && !freeAvail;
  assign abortNow    = conflictNow || explicitNow || overflowNow;
  assign drainLast   = inDrain && (drainPtr == LAST_IDX);

  assign stb.accept   = accessNow && !overflowNow;
  assign stb.clearAll = abortNow || drainLast;

  assign accHit       = stb.accept && lookupHit;
  assign accStall     = inDrain;
  assign drainValid   = inDrain && slotDirty;
  assign commitDone   = drainLast;
  assign abortPending = (state == ST_ABORTED);
  assign abortCause   = cause;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cause    <= CAUSE_NONE;
      drainPtr <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_ABORTED: begin
          if (txBegin) begin
            state <= ST_ACTIVE;
            cause <= CAUSE_NONE;
          end
        end
        ST_ACTIVE: begin
          if (conflictNow) begin
            state <= ST_ABORTED;
            cause <= CAUSE_CONFLICT;
          end else if (explicitNow) begin
            state <= ST_ABORTED;
            cause <= CAUSE_EXPLICIT;
          end else if (commitNow) begin
            state    <= ST_DRAIN;
            drainPtr <= '0;
          end else if (overflowNow) begin
            state <= ST_ABORTED;
            cause <= CAUSE_OVERFLOW;
          end
        end
        ST_DRAIN: begin
          drainPtr <= drainPtr + 1'b1;
          if (drainLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_conflict_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    conflictNow |=> (abortPending && abortCause == 2'b10));

  p_explicit_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    explicitNow |=> (abortPending && abortCause == 2'b01));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflowNow |=> (abortPending && abortCause == 2'b11));

  p_refuse_aborted_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortPending |-> (!accHit && !drainValid));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> (!accStall && !abortPending));

  p_snoop_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txCommit && conflictNow) |=> (abortPending && !accStall));

  p_cause_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (abortPending && !txBegin) |=> (abortPending && $stable(abortCause)));

endmodule

// File: rtl/tx_write_buffer.sv
module tx_write_buffer
  import twb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txCommit,
  input  logic              txAbort,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] accRdata,
  output logic              accHit,
  output logic              accStall,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic              commitDone,
  output logic              abortPending,
  output logic [1:0]        abortCause
);

  twbStrobe_t       stb;
  logic [IDX_W-1:0] drainPtr;
  logic             lookupHit, freeAvail, snoopHit, slotDirty;

  assign memRdAddr = accAddr;

  twb_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .accValid(accValid), .snoopValid(snoopValid),
    .lookupHit(lookupHit), .freeAvail(freeAvail),
    .snoopHit(snoopHit), .slotDirty(slotDirty),
    .stb(stb), .drainPtr(drainPtr),
    .accHit(accHit), .accStall(accStall),
    .drainValid(drainValid), .commitDone(commitDone),
    .abortPending(abortPending), .abortCause(abortCause)
  );

  twb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .drainPtr(drainPtr),
    .accWrite(accWrite), .accAddr(accAddr), .accWdata(accWdata),
    .memRdData(memRdData), .snoopAddr(snoopAddr),
    .lookupHit(lookupHit), .freeAvail(freeAvail),
    .snoopHit(snoopHit), .slotDirty(slotDirty),
    .accRdata(accRdata), .drainAddr(drainAddr), .drainData(drainData)
  );

endmodule

// File: tb/tx_write_buffer_tb.sv
module tx_write_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txBegin = 0, txCommit = 0, txAbort = 0;
  logic        accValid = 0, accWrite = 0;
  logic [15:0] accAddr = '0;
  logic [31:0] accWdata = '0;
  logic [31:0] accRdata;
  logic        accHit, accStall;
  logic [15:0] memRdAddr;
  logic [31:0] memRdData;
  logic        snoopValid = 0;
  logic [15:0] snoopAddr = '0;
  logic        drainValid;
  logic [15:0] drainAddr;
  logic [31:0] drainData;
  logic        commitDone, abortPending;
  logic [1:0]  abortCause;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Model: 0 idle, 1 active, 2 aborted
  int          mState = 0;
  logic [1:0]  mCause = 2'b00;
  logic        mValid [NE];
  logic [15:0] mTag   [NE];
  logic [31:0] mOld   [NE];
  logic [31:0] mNew   [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memVal(input logic [15:0] a);
    return {a, ~a} ^ 32'h3C5A_96E1;
  endfunction

  assign memRdData = memVal(memRdAddr);

  tx_write_buffer u_dut (
    .clk(clk), .rstN(rstN),
    .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .accWdata(accWdata),
    .accRdata(accRdata), .accHit(accHit), .accStall(accStall),
    .memRdAddr(memRdAddr), .memRdData(memRdData),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .drainValid(drainValid), .drainAddr(drainAddr), .drainData(drainData),
    .commitDone(commitDone), .abortPending(abortPending), .abortCause(abortCause)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < NE; i++) mValid[i] = 1'b0;
  endtask

  task automatic modelAbort(input logic [1:0] c);
    mState = 2; mCause = c; modelClear();
  endtask

  task automatic checkStatus(input string req);
    chk(abortPending == (mState == 2), req, 32'(abortPending), 32'(mState == 2));
    chk(abortCause == mCause, req, 32'(abortCause), 32'(mCause));
  endtask

  task automatic beginTx();
    txBegin = 1; @(negedge clk); txBegin = 0;
    if (mState != 1) begin mState = 1; mCause = 2'b00; end
    checkStatus("R11 begin clears status");
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [31:0] d);
    int hi = -1;
    int fr = -1;
    bit ovf = 0;
    accValid = 1; accWrite = w; accAddr = a; accWdata = d;
    #1;
    if (mState == 1) begin
      for (int i = 0; i < NE; i++) if (mValid[i] && mTag[i] == a) hi = i;
      for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) fr = i;
      if (hi >= 0) begin
        chk(accHit == 1'b1, "R3 later touch hits", 32'(accHit), 32'd1);
        chk(accRdata == mNew[hi], "R4 read returns new copy", accRdata, mNew[hi]);
      end else if (fr >= 0) begin
        chk(accHit == 1'b0, "R3 first touch misses", 32'(accHit), 32'd0);
        chk(accRdata == memVal(a), "R3 first touch backing value", accRdata, memVal(a));
      end else begin
        ovf = 1;
        chk(accHit == 1'b0, "R7 overflow access not hit", 32'(accHit), 32'd0);
      end
    end else if (mState == 2) begin
      chk(accHit == 1'b0, "R8 refused after abort", 32'(accHit), 32'd0);
    end else begin
      chk(accHit == 1'b0, "R2 refused while idle", 32'(accHit), 32'd0);
    end
    @(negedge clk);
    accValid = 0;
    if (mState == 1) begin
      if (hi >= 0) begin
        if (w) mNew[hi] = d;
      end else if (!ovf) begin
        mValid[fr] = 1; mTag[fr] = a; mOld[fr] = memVal(a);
        mNew[fr] = w ? d : memVal(a);
      end else begin
        modelAbort(2'b11);
      end
    end
    checkStatus("R7 status after access");
  endtask

  task automatic drainCheck();
    for (int i = 0; i < NE; i++) begin
      bit expV;
      accValid = 1; accWrite = 1;
      accAddr = mValid[i] ? mTag[i] : 16'(i); accWdata = $urandom;
      #1;
      expV = mValid[i] && (mNew[i] != mOld[i]);
      chk(accStall == 1'b1, "R9 stall during drain", 32'(accStall), 32'd1);
      chk(accHit == 1'b0, "R9 access refused in drain", 32'(accHit), 32'd0);
      chk(drainValid == expV, "R9 drain valid", 32'(drainValid), 32'(expV));
      if (expV) begin
        chk(drainAddr == mTag[i], "R9 drain address", 32'(drainAddr), 32'(mTag[i]));
        chk(drainData == mNew[i], "R9 drain data", drainData, mNew[i]);
      end
      chk(commitDone == (i == NE - 1), "R9 done timing", 32'(commitDone), 32'(i == NE - 1));
      @(negedge clk);
    end
    accValid = 0;
    modelClear(); mState = 0;
    chk(accStall == 1'b0, "R9 idle after drain", 32'(accStall), 32'd0);
    checkStatus("R9 status after commit");
  endtask

  task automatic commitTx();
    txCommit = 1; @(negedge clk); txCommit = 0;
    if (mState == 1) drainCheck();
    else begin
      chk(accStall == 1'b0, "R8 commit ignored after abort", 32'(accStall), 32'd0);
      checkStatus("R8 commit ignored");
    end
  endtask

  task automatic abortTx();
    txAbort = 1; @(negedge clk); txAbort = 0;
    if (mState == 1) modelAbort(2'b01);
    checkStatus("R6 explicit abort");
  endtask

  task automatic snoopEv(input logic [15:0] a, input bit withCommit);
    bit hit = 0;
    for (int i = 0; i < NE; i++) if (mValid[i] && mTag[i] == a) hit = 1;
    snoopValid = 1; snoopAddr = a; txCommit = withCommit;
    @(negedge clk);
    snoopValid = 0; txCommit = 0;
    if (mState == 1 && hit) begin
      modelAbort(2'b10);
      checkStatus("R5 snoop conflict");
      if (withCommit)
        chk(accStall == 1'b0, "R10 snoop beats commit", 32'(accStall), 32'd0);
    end else begin
      checkStatus("R5 unrelated snoop");
      if (withCommit && mState == 1) drainCheck();
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(abortPending == 0, "R1 reset pending", 32'(abortPending), 0);
    chk(abortCause == 0, "R1 reset cause", 32'(abortCause), 0);
    chk(accStall == 0 && drainValid == 0 && commitDone == 0, "R1 reset outputs",
        {accStall, drainValid, commitDone}, 0);

    // R2: idle write leaves no trace
    access(1, 16'h0005, 32'hDEAD_BEEF);
    beginTx();
    access(0, 16'h0005, 0);
    access(1, 16'h0005, 32'h1111_2222);
    access(0, 16'h0005, 0);
    // write back original value: not drained (R9)
    access(1, 16'h0009, memVal(16'h0009));
    access(1, 16'h000A, 32'hCAFE_0001);
    snoopEv(16'h0100, 0);          // R5 unrelated snoop
    commitTx();

    // R10: snoop and commit in the same cycle
    beginTx();
    access(0, 16'h0003, 0);
    snoopEv(16'h0003, 1);
    access(0, 16'h0003, 0);        // R8 refused
    abortTx();                     // ignored while aborted
    commitTx();                    // ignored while aborted

    // R7: overflow after all slots are taken
    beginTx();
    for (int i = 0; i < NE; i++) access(1, 16'(16'h0040 + i), 32'(i * 3 + 1));
    access(0, 16'h0040, 0);        // hit, still fine
    access(1, 16'h0077, 32'h5);    // overflow
    beginTx();
    access(0, 16'h0040, 0);        // R8: dropped slot misses now
    abortTx();

    // R6 explicit abort, then fresh transaction
    beginTx();
    access(1, 16'h0020, 32'h1234);
    abortTx();
    beginTx();
    access(0, 16'h0020, 0);
    commitTx();

    // Random transactions
    for (int t = 0; t < 60; t++) begin
      int n;
      beginTx();
      n = 1 + ($urandom % 12);
      for (int k = 0; k < n; k++) begin
        logic [15:0] a;
        logic [31:0] d;
        a = 16'($urandom % 12);
        d = (($urandom % 5) == 0) ? memVal(a) : $urandom;
        access(1'($urandom % 2), a, d);
        if (($urandom % 10) == 0) snoopEv(16'($urandom % 24), 0);
      end
      case ($urandom % 5)
        0: abortTx();
        1: snoopEv(16'($urandom % 12), 1);
        default: commitTx();
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule